// File: doc/BRIEF.md
# Delayed-Branch Program Counter Sequencer

This block steps the program counter of a 32-bit RISC core whose control transfers take effect after one delay-slot instruction. It holds two addresses: the fetch address of the instruction being retired now, and the address that follows it. On every step strobe the fetch address takes over the following address, and the following address moves ahead by one word. If the retiring instruction is a taken branch, an absolute jump or a register jump, the following address is then replaced by the target. The delay-slot instruction therefore always runs before the transfer.

The decoder gives it the kind of control transfer, the branch condition, a likely flag, a link flag, the immediate and jump-target fields, and the two register operands. The block returns the fetch address and a link-write request that names the register and gives the return address. It also raises an annul flag. A likely branch that is not taken cancels its delay-slot instruction. While annul is high, the instruction at the fetch address must not commit. The sequencer itself does not evaluate it and does not let it link.

Top module: `npc_unit`

## Requirements
- R1: A synchronous reset makes fetch_pc 0, makes the held following address 4 (seen as link_data = 8), and clears annul.
- R2: On a step with ctl_kind 0 (sequential), fetch_pc takes the old following address and the following address grows by 4. With step low, fetch_pc and the following address hold.
- R3: ctl_kind 1 is a conditional branch. When it is taken, the new following address is the old following address plus the sign-extended imm16 shifted left by two. This equals the incremented address plus (offset*4 - 4).
- R4: br_cond encodes the test: 0 rs==rt, 1 rs!=rt, 2 rs<0, 3 rs>=0, 4 rs<=0, 5 rs>0. The one-register tests treat rs as signed two's complement.
- R5: ctl_kind 2 is an absolute jump. The new following address is the top 4 bits of the delay-slot address (the old following address) joined with jtarget and two zero bits.
- R6: ctl_kind 3 is a register jump. The new following address is rs_val. With link set, the request names link_dst.
- R7: A link request (link_we) is raised during a step for any non-sequential kind with link set, whether or not a branch is taken. It names register 31 for kinds 1 and 2. Its data is the old following address plus 4.
- R8: A likely branch (likely=1, kind 1) that is not taken raises annul after its step. The next step clears annul. During that next step there is no link request and no redirect, but the PC pair still advances by one word.
- R9: A likely branch that is taken does not raise annul and redirects as in R3. The likely flag has no effect on kinds 0, 2 and 3.
- R10: link_we is low whenever step is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Retire the instruction at fetch_pc this cycle |
| ctl_kind | input | 2 | 0 sequential, 1 branch, 2 absolute jump, 3 register jump |
| br_cond | input | 3 | Branch condition code (see R4) |
| likely | input | 1 | Branch cancels its delay slot when not taken |
| link | input | 1 | Transfer writes a return address |
| imm16 | input | 16 | Branch immediate, word offset |
| jtarget | input | 26 | Absolute jump word target |
| rs_val | input | 32 | First register operand / jump register |
| rt_val | input | 32 | Second register operand |
| link_dst | input | 5 | Link register for register jumps |
| fetch_pc | output | 32 | Address of the instruction being retired |
| annul | output | 1 | Instruction at fetch_pc is cancelled |
| link_we | output | 1 | Link write request |
| link_reg | output | 5 | Register that takes the link |
| link_data | output | 32 | Return address |

## Verification
Two events can fall on the same step. A link-and-branch instruction raises a link write and also decides a redirect. A likely branch that is not taken suppresses the next instruction's link and redirect while the pair still advances. The sweep covers every condition over signed edge operands, crossed with likely and link. Every untaken likely branch is followed at once by an instruction that asks to link, so the annulled step always has a link request to suppress. Each step is judged against a bench model of the PC pair and skip flag, through fetch_pc and through link_data, which shows the held following address.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN = 32;
  localparam int IMMW = 16;
  localparam int TGTW = 26;
  localparam int REGW = 5;
  localparam int STEP = 4;
  localparam int HIKEEP = XLEN - TGTW - 2;
  localparam logic [REGW-1:0] RA_REG = REGW'(31);

  typedef enum logic [1:0] {
    K_SEQ    = 2'd0,
    K_BRANCH = 2'd1,
    K_JABS   = 2'd2,
    K_JREG   = 2'd3
  } ctl_kind_e;

  typedef enum logic [2:0] {
    C_EQ  = 3'd0,
    C_NE  = 3'd1,
    C_LTZ = 3'd2,
    C_GEZ = 3'd3,
    C_LEZ = 3'd4,
    C_GTZ = 3'd5
  } cond_e;

  // sign-extended word offset minus one word, added to the incremented address
  function automatic logic [XLEN-1:0] br_adjust(input logic [IMMW-1:0] imm);
    logic [XLEN-1:0] sx;
    sx = {{(XLEN-IMMW){imm[IMMW-1]}}, imm};
    return (sx << 2) - XLEN'(STEP);
  endfunction

  function automatic logic [XLEN-1:0] jabs_pc(input logic [XLEN-1:0] slot,
                                              input logic [TGTW-1:0] tgt);
    return {slot[XLEN-1 -: HIKEEP], tgt, 2'b00};
  endfunction
endpackage

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
(
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            taken
);
  logic same, a_zero, a_neg;

  assign same   = (a == b);
  assign a_zero = (a == '0);
  assign a_neg  = a[XLEN-1];

  always_comb begin
    case (cond_e'(cond))
      C_EQ:    taken = same;
      C_NE:    taken = !same;
      C_LTZ:   taken = a_neg;
      C_GEZ:   taken = !a_neg;
      C_LEZ:   taken = a_neg || a_zero;
      C_GTZ:   taken = !a_neg && !a_zero;
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
(
  input  logic [1:0]      kind,
  input  logic            active,
  input  logic            taken,
  input  logic [XLEN-1:0] npc_q,
  input  logic [IMMW-1:0] imm,
  input  logic [TGTW-1:0] tgt,
  input  logic [XLEN-1:0] rs,
  output logic            redirect,
  output logic [XLEN-1:0] seq_npc,
  output logic [XLEN-1:0] redir_pc
);
  assign seq_npc = npc_q + XLEN'(STEP);

  always_comb begin
    redirect = 1'b0;
    redir_pc = seq_npc;
    case (ctl_kind_e'(kind))
      K_BRANCH: begin
        redirect = active && taken;
        redir_pc = seq_npc + br_adjust(imm);
      end
      K_JABS: begin
        redirect = active;
        redir_pc = jabs_pc(npc_q, tgt);
      end
      K_JREG: begin
        redirect = active;
        redir_pc = rs;
      end
      default: begin
        redirect = 1'b0;
        redir_pc = seq_npc;
      end
    endcase
  end
endmodule

// File: rtl/npc_link.sv
module npc_link
  import npc_pkg::*;
(
  input  logic            step,
  input  logic            annul,
  input  logic [1:0]      kind,
  input  logic            link,
  input  logic [XLEN-1:0] ret_addr,
  input  logic [REGW-1:0] dst,
  output logic            we,
  output logic [REGW-1:0] wreg,
  output logic [XLEN-1:0] wdata
);
  logic xfer;

  assign xfer  = (ctl_kind_e'(kind) != K_SEQ);
  assign we    = step && !annul && link && xfer;
  assign wreg  = (ctl_kind_e'(kind) == K_JREG) ? dst : RA_REG;
  assign wdata = ret_addr;
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        step,
  input  logic [1:0]  ctl_kind,
  input  logic [2:0]  br_cond,
  input  logic        likely,
  input  logic        link,
  input  logic [15:0] imm16,
  input  logic [25:0] jtarget,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  input  logic [4:0]  link_dst,
  output logic [31:0] fetch_pc,
  output logic        annul,
  output logic        link_we,
  output logic [4:0]  link_reg,
  output logic [31:0] link_data
);
  logic [XLEN-1:0] pc_q, npc_q;
  logic            skip_q;
  logic            active, taken, redirect, cancel_slot, is_branch;
  logic [XLEN-1:0] seq_npc, redir_pc;

  assign active      = step && !skip_q;
  assign is_branch   = (ctl_kind_e'(ctl_kind) == K_BRANCH);
  assign cancel_slot = active && is_branch && likely && !taken;

  npc_cond u_cond (
    .cond  (br_cond),
    .a     (rs_val),
    .b     (rt_val),
    .taken (taken)
  );

  npc_target u_target (
    .kind     (ctl_kind),
    .active   (active),
    .taken    (taken),
    .npc_q    (npc_q),
    .imm      (imm16),
    .tgt      (jtarget),
    .rs       (rs_val),
    .redirect (redirect),
    .seq_npc  (seq_npc),
    .redir_pc (redir_pc)
  );

  npc_link u_link (
    .step     (step),
    .annul    (skip_q),
    .kind     (ctl_kind),
    .link     (link),
    .ret_addr (seq_npc),
    .dst      (link_dst),
    .we       (link_we),
    .wreg     (link_reg),
    .wdata    (link_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= RESET_PC;
      npc_q  <= RESET_PC + XLEN'(STEP);
      skip_q <= 1'b0;
    end else if (step) begin
      pc_q   <= npc_q;
      npc_q  <= redirect ? redir_pc : seq_npc;
      skip_q <= cancel_slot;
    end
  end

  assign fetch_pc = pc_q;
  assign annul    = skip_q;

  AST_RESET_PAIR: assert property (@(posedge clk) rst |=> (pc_q == RESET_PC && !skip_q)) else $error("reset pair"); // R1
  AST_HOLD_PAIR: assert property (@(posedge clk) disable iff (rst) !step |=> ($stable(pc_q) && $stable(npc_q))) else $error("hold"); // R2
  AST_PC_FOLLOWS: assert property (@(posedge clk) disable iff (rst) step |=> pc_q == $past(npc_q)) else $error("pc follow"); // R2
  AST_BR_TARGET: assert property (@(posedge clk) disable iff (rst) (active && is_branch && taken) |=> npc_q == $past(npc_q) + {{14{$past(imm16[15])}}, $past(imm16), 2'b00}) else $error("branch target"); // R3
  AST_ANNUL_ONCE: assert property (@(posedge clk) disable iff (rst) (step && skip_q) |=> !skip_q) else $error("annul twice"); // R8
  AST_ANNUL_NOLINK: assert property (@(posedge clk) disable iff (rst) skip_q |-> !link_we) else $error("annulled link"); // R8
  AST_ANNUL_NOREDIR: assert property (@(posedge clk) disable iff (rst) (step && skip_q) |=> npc_q == $past(npc_q) + 32'd4) else $error("annulled redirect"); // R8
  AST_LINK_STEP: assert property (@(posedge clk) disable iff (rst) !step |-> !link_we) else $error("link without step"); // R10
endmodule

// File: tb/sim_npc_unit.sv
module sim_npc_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [1:0]  ctl_kind = '0;
  logic [2:0]  br_cond = '0;
  logic        likely = 1'b0;
  logic        link = 1'b0;
  logic [15:0] imm16 = '0;
  logic [25:0] jtarget = '0;
  logic [31:0] rs_val = '0;
  logic [31:0] rt_val = '0;
  logic [4:0]  link_dst = '0;
  logic [31:0] fetch_pc;
  logic        annul;
  logic        link_we;
  logic [4:0]  link_reg;
  logic [31:0] link_data;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  logic [31:0] m_pc, m_npc;
  logic        m_skip;

  always #5 clk = ~clk;

  npc_unit u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit ref_cond(input int c, input logic [31:0] a, input logic [31:0] b);
    int signed sa;
    sa = a;
    case (c)
      0: return a == b;
      1: return a != b;
      2: return sa < 0;
      3: return sa >= 0;
      4: return sa <= 0;
      5: return sa > 0;
      default: return 0;
    endcase
  endfunction

  task automatic do_step(input int kind, input int c, input bit lik, input bit lnk,
                         input logic [15:0] imm, input logic [25:0] tgt,
                         input logic [31:0] a, input logic [31:0] b, input logic [4:0] dst);
    bit act, tk, exp_we;
    logic [31:0] nn, off;
    @(negedge clk);
    step = 1; ctl_kind = kind[1:0]; br_cond = c[2:0]; likely = lik; link = lnk;
    imm16 = imm; jtarget = tgt; rs_val = a; rt_val = b; link_dst = dst;
    act = !m_skip;
    tk = ref_cond(c, a, b);
    exp_we = act && lnk && (kind != 0);
    #1;
    if (m_skip) chk("R8 link suppressed while annulled", {31'd0, link_we}, {31'd0, exp_we});
    else if (kind == 3) chk("R6 link request on register jump", {31'd0, link_we}, {31'd0, exp_we});
    else chk("R7 link request regardless of outcome", {31'd0, link_we}, {31'd0, exp_we});
    if (exp_we) begin
      chk(kind == 3 ? "R6 link register" : "R7 link register 31", {27'd0, link_reg},
          kind == 3 ? {27'd0, dst} : 32'd31);
      chk("R7 link data", link_data, m_npc + 32'd4);
    end
    nn = m_npc + 32'd4;
    off = {{14{imm[15]}}, imm, 2'b00};
    if (act) begin
      if (kind == 1 && tk) nn = m_npc + off;
      if (kind == 2) nn = {m_npc[31:28], tgt, 2'b00};
      if (kind == 3) nn = a;
    end
    m_skip = act && kind == 1 && lik && !tk;
    m_pc = m_npc;
    m_npc = nn;
    @(posedge clk);
    #1;
    step = 0; link = 0;
    chk("R2 fetch_pc takes following address", fetch_pc, m_pc);
    chk(kind == 1 ? (lik ? "R9 likely annul flag" : "R8 annul flag") : "R8 annul flag",
        {31'd0, annul}, {31'd0, m_skip});
    chk(kind == 1 ? "R3 R4 following address" : (kind == 2 ? "R5 following address" :
        (kind == 3 ? "R6 following address" : "R2 following address")),
        link_data, m_npc + 32'd4);
  endtask

  initial begin
    logic [31:0] vals [6];
    logic [15:0] imms [4];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'hffff_ffff;
    vals[3] = 32'h7fff_ffff; vals[4] = 32'h8000_0000; vals[5] = 32'h5;
    imms[0] = 16'h0003; imms[1] = 16'hfffe; imms[2] = 16'h8000; imms[3] = 16'h7fff;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset fetch_pc", fetch_pc, 32'h0);
    chk("R1 reset annul", {31'd0, annul}, 32'd0);
    chk("R1 reset following address", link_data, 32'd8);
    @(negedge clk);
    rst = 0;
    m_pc = 0; m_npc = 4; m_skip = 0;
    // R10 / R2: step low, transfer with link presented
    @(negedge clk);
    ctl_kind = 2'd3; link = 1; rs_val = 32'h1234_5678;
    #1;
    chk("R10 no link without step", {31'd0, link_we}, 32'd0);
    @(posedge clk);
    #1;
    chk("R2 hold fetch_pc", fetch_pc, m_pc);
    chk("R2 hold following address", link_data, m_npc + 32'd4);
    link = 0; ctl_kind = 0;
    // sequential steps
    for (int i = 0; i < 4; i++) do_step(0, 0, i[0], 1, 16'h0, 26'h0, 32'h0, 32'h0, 5'd3);
    // condition sweep crossed with likely and link
    for (int c = 0; c < 6; c++)
      for (int ia = 0; ia < 6; ia++)
        for (int ib = 0; ib < 6; ib++)
          for (int m = 0; m < 4; m++) begin
            do_step(1, c, m[0], m[1], imms[(ia + ib + m) % 4], 26'h0, vals[ia], vals[ib], 5'd0);
            if (m_skip) do_step(3, 0, 0, 1, 16'h0, 26'h0, 32'h0000_0400, 32'h0, 5'd9);
          end
    // absolute jumps, including a link, and likely flag ignored
    for (int j = 0; j < 8; j++) begin
      do_step(3, 0, 0, 0, 16'h0, 26'h0, {j[3:0], 28'h000_0100}, 32'h0, 5'd1);
      do_step(2, 0, j[1], j[0], 16'h0, 26'h1555555 ^ 26'(j * 26'h0123457), 32'h0, 32'h0, 5'd0);
    end
    // register jumps with various destinations
    for (int k = 0; k < 8; k++)
      do_step(3, 0, k[2], k[0], 16'h0, 26'h0, 32'h8000_0000 + 32'(k * 16), 32'h0, 5'(k * 3 + 1));
    // likely not taken followed by a jump that must be ignored
    do_step(1, 0, 1, 1, 16'h0010, 26'h0, 32'h1, 32'h2, 5'd0);
    do_step(2, 0, 0, 1, 16'h0, 26'h3ff_ffff, 32'h0, 32'h0, 5'd0);
    do_step(0, 0, 0, 0, 16'h0, 26'h0, 32'h0, 32'h0, 5'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog R2 actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule